// File: doc/BRIEF.md
# Reloadable Down-Counting Timer with APB Register Access

This block is a 32-bit periodic timer that sits behind an APB slave port and drives one level interrupt line. Software loads a start value, picks where count steps come from, and enables the timer. The counter then steps down once per qualified tick. On the step from one to zero it can flag an interrupt. It stays at zero for one more tick and then restarts from the stored reload value, so it gives a fixed period without software help.

Count steps come from one of three sources, chosen by control bits. The first is every APB clock cycle. The second is clock cycles gated by an external level. The third is rising edges of that external signal. The external pin passes through a two-flop synchronizer before any of these uses. The interrupt flag is cleared by writing a one to it. A read-only bank of identification bytes near the top of the 4 KB window lets software recognise the block.

Top module: `apb_dcount_timer`

## Requirements
- R1: After reset is asserted, the control register, the counter, the reload register and the interrupt flag all read zero, and `irq_out` is low. `pready` is always high and `pslverr` always low.
- R2: The control register sits at offset 0x000 and keeps only bits [3:0]: bit 0 is run, bit 1 is external gate, bit 2 is external tick and bit 3 is interrupt enable. Bits [31:4] always read zero.
- R3: With run set and both external bits clear, the counter at offset 0x004 drops by one on every `pclk` cycle. With run clear it holds its value.
- R4: When the counter steps from 1 to 0 with interrupt enable set, the flag at offset 0x00C bit 0 sets and `irq_out` follows it. If interrupt enable is clear at that step, the flag stays clear.
- R5: A tick that finds the counter at zero loads the reload value. The counter therefore shows zero for exactly one tick.
- R6: With a reload value of zero, the counter stays at zero once it gets there, and no further interrupt is raised.
- R7: Writing the reload register at offset 0x008 sets both the reload register and the counter. Writing the counter sets only the counter. A write takes priority over a tick in the same cycle.
- R8: Writing 1 to bit 0 at offset 0x00C clears the flag. If a 1-to-0 step with interrupt enable happens in the same cycle, the flag stays set.
- R9: In external gate mode (bits 1 and 0 set), the counter steps on each `pclk` cycle only while the synchronized `ext_in` is high. This adds a latency of two cycles.
- R10: In external tick mode (bits 2 and 0 set), the counter steps once per rising edge of the synchronized `ext_in`, however long the input stays high.
- R11: Word offsets 0xFD0 to 0xFFC return one identification byte each, in order: 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them change nothing.
- R12: Reads at any other offset return zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB and timer clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when not selected |
| pready | output | 1 | Constant high, no wait states |
| pslverr | output | 1 | Constant low, no error responses |
| ext_in | input | 1 | External gate level or tick source |
| irq_out | output | 1 | Level interrupt, equal to the flag |

## Verification
The countdown is run with a reload of three and the interrupt enabled. This shows the single zero tick, the periodic restart, and whether the interrupt is raised again after a clear. The same run with interrupt enable clear separates reaching zero from setting the flag. A zero reload, first from reset and then after a direct counter write, separates a one-shot from a periodic count. In external gate mode `ext_in` is held high and then dropped, which measures the two-cycle synchronizer delay at both ends. In tick mode, pulses that stay high for three cycles show one step per edge rather than one per high cycle. A clear that lands on the same cycle as a 1-to-0 step shows which of the two wins.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

  // Window is 4 KB, byte addressed
  localparam int unsigned WIN_ADDR_W = 12;

  localparam logic [WIN_ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [WIN_ADDR_W-1:0] OFS_COUNT  = 12'h004;
  localparam logic [WIN_ADDR_W-1:0] OFS_RELOAD = 12'h008;
  localparam logic [WIN_ADDR_W-1:0] OFS_FLAG   = 12'h00C;
  localparam logic [WIN_ADDR_W-1:0] OFS_IDENT  = 12'hFD0;

  localparam int unsigned IDENT_WORDS = 12;
  localparam int unsigned CTRL_W      = 4;

  // Bit 3 down to bit 0 of the control register
  typedef struct packed {
    logic irq_en;
    logic ext_tick;
    logic ext_gate;
    logic run;
  } ctrl_t;

  function automatic logic [7:0] ident_byte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = 8'h22;
      4'd5:    b = 8'hB8;
      4'd6:    b = 8'h1B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dtimer_tick_gen.sv
module dtimer_tick_gen #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic run,
  input  logic ext_gate,
  input  logic ext_tick,
  output logic tick
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   ext_lvl;
  logic                   ext_rise;
  logic                   gate_ok;
  logic                   step_ok;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      assign sync_d = ext_in;
    end else begin : g_chain
      assign sync_d = {sync_q[LAST-1:0], ext_in};
    end
  endgenerate

  always_comb begin
    ext_lvl  = sync_q[LAST];
    prev_d   = ext_lvl;
    ext_rise = ext_lvl & ~prev_q;
    gate_ok  = ext_gate ? ext_lvl : 1'b1;
    step_ok  = ext_tick ? ext_rise : 1'b1;
    tick     = run & gate_ok & step_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/dtimer_counter.sv
module dtimer_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_count,
  input  logic         wr_reload,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] reload,
  output logic         reach_zero
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] rel_q, rel_d;
  logic         any_wr;

  always_comb begin
    cnt_d  = cnt_q;
    rel_d  = rel_q;
    any_wr = wr_count | wr_reload;
    if (wr_reload) begin
      rel_d = wdata;
      cnt_d = wdata;
    end else if (wr_count) begin
      cnt_d = wdata;
    end else if (tick) begin
      cnt_d = (cnt_q == '0) ? rel_q : cnt_q - ONE;
    end
    reach_zero = tick & ~any_wr & (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign count  = cnt_q;
  assign reload = rel_q;

endmodule

// File: rtl/dtimer_regs.sv
module dtimer_regs
  import dtimer_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [WIN_ADDR_W-1:0] paddr,
  input  logic [CTRL_W-1:0]     ctl_wdata,
  input  logic [W-1:0]          count,
  input  logic [W-1:0]          reload,
  input  logic                  reach_zero,
  output logic [W-1:0]          prdata,
  output ctrl_t                 ctrl,
  output logic                  wr_count,
  output logic                  wr_reload,
  output logic                  flag
);

  localparam logic [5:0] IDENT_HI = OFS_IDENT[WIN_ADDR_W-1:6];
  localparam logic [3:0] IDENT_LO = OFS_IDENT[5:2];
  localparam logic [3:0] IDENT_TOP = IDENT_LO + 4'(IDENT_WORDS - 1);

  ctrl_t        ctrl_q, ctrl_d;
  logic         flag_q, flag_d;
  logic         wr_acc;
  logic         wr_ctrl;
  logic         wr_flag;
  logic         in_ident;
  logic [3:0]   ident_idx;
  logic [W-1:0] rdata;

  always_comb begin
    wr_acc    = psel & penable & pwrite;
    wr_ctrl   = wr_acc & (paddr == OFS_CTRL);
    wr_count  = wr_acc & (paddr == OFS_COUNT);
    wr_reload = wr_acc & (paddr == OFS_RELOAD);
    wr_flag   = wr_acc & (paddr == OFS_FLAG);

    ctrl_d = wr_ctrl ? ctrl_t'(ctl_wdata) : ctrl_q;

    // A set in the same cycle as a clear wins
    if (reach_zero && ctrl_q.irq_en)
      flag_d = 1'b1;
    else if (wr_flag && ctl_wdata[0])
      flag_d = 1'b0;
    else
      flag_d = flag_q;
  end

  always_comb begin
    in_ident  = (paddr[WIN_ADDR_W-1:6] == IDENT_HI) && (paddr[5:2] >= IDENT_LO)
                && (paddr[5:2] <= IDENT_TOP) && (paddr[1:0] == 2'b00);
    ident_idx = paddr[5:2] - IDENT_LO;
    rdata     = '0;
    if (paddr == OFS_CTRL)
      rdata[CTRL_W-1:0] = ctrl_q;
    else if (paddr == OFS_COUNT)
      rdata = count;
    else if (paddr == OFS_RELOAD)
      rdata = reload;
    else if (paddr == OFS_FLAG)
      rdata[0] = flag_q;
    else if (in_ident)
      rdata[7:0] = ident_byte(ident_idx);
    prdata = psel ? rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  assign ctrl = ctrl_q;
  assign flag = flag_q;

endmodule

// File: rtl/apb_dcount_timer.sv
module apb_dcount_timer
  import dtimer_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  pclk,
  input  logic                  presetn,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [WIN_ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0]     pwdata,
  output logic [DATA_W-1:0]     prdata,
  output logic                  pready,
  output logic                  pslverr,
  input  logic                  ext_in,
  output logic                  irq_out
);

  ctrl_t             ctrl_q;
  logic              tick;
  logic              wr_count;
  logic              wr_reload;
  logic              reach_zero;
  logic [DATA_W-1:0] cnt_val;
  logic [DATA_W-1:0] rel_val;

  dtimer_tick_gen #(
    .SYNC_STAGES (SYNC_STAGES)
  ) i_tick (
    .clk      (pclk),
    .rst_n    (presetn),
    .ext_in   (ext_in),
    .run      (ctrl_q.run),
    .ext_gate (ctrl_q.ext_gate),
    .ext_tick (ctrl_q.ext_tick),
    .tick     (tick)
  );

  dtimer_counter #(
    .W (DATA_W)
  ) i_cnt (
    .clk        (pclk),
    .rst_n      (presetn),
    .tick       (tick),
    .wr_count   (wr_count),
    .wr_reload  (wr_reload),
    .wdata      (pwdata),
    .count      (cnt_val),
    .reload     (rel_val),
    .reach_zero (reach_zero)
  );

  dtimer_regs #(
    .W (DATA_W)
  ) i_regs (
    .clk        (pclk),
    .rst_n      (presetn),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .ctl_wdata  (pwdata[CTRL_W-1:0]),
    .count      (cnt_val),
    .reload     (rel_val),
    .reach_zero (reach_zero),
    .prdata     (prdata),
    .ctrl       (ctrl_q),
    .wr_count   (wr_count),
    .wr_reload  (wr_reload),
    .flag       (irq_out)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk #(
  parameter int unsigned W = 32
) (
  input logic         pclk,
  input logic         presetn,
  input logic         psel,
  input logic         penable,
  input logic         pwrite,
  input logic [11:0]  paddr,
  input logic         wbit0,
  input logic [W-1:0] prdata,
  input logic         irq_out,
  input logic         tick,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] rel_val,
  input logic [3:0]   ctrl_bits
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic wr_acc, wr_cnt, wr_rel, wr_flg, no_wr;
  assign wr_acc = psel & penable & pwrite;
  assign wr_cnt = wr_acc & (paddr == 12'h004);
  assign wr_rel = wr_acc & (paddr == 12'h008);
  assign wr_flg = wr_acc & (paddr == 12'h00C);
  assign no_wr  = ~wr_cnt & ~wr_rel;

  p_ctrl_upper_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && paddr == 12'h000) |-> (prdata[W-1:4] == '0));

  p_step_down_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (tick && no_wr && cnt_val > ONE) |=> (cnt_val == $past(cnt_val) - ONE));

  p_hold_idle_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (!tick && no_wr) |=> $stable(cnt_val));

  p_tick_needs_run_r9: assert property (@(posedge pclk) disable iff (!presetn)
    tick |-> ctrl_bits[0]);

  p_flag_source_r4: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(irq_out) |-> ($past(tick) && $past(ctrl_bits[3]) && $past(cnt_val) == ONE));

  p_zero_reload_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (tick && no_wr && cnt_val == '0) |=> (cnt_val == $past(rel_val)));

  p_zero_stays_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (cnt_val == '0 && rel_val == '0 && no_wr) |=> (cnt_val == '0 && !$rose(irq_out)));

  p_clear_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_flg && wbit0 && !(tick && no_wr && ctrl_bits[3] && cnt_val == ONE)) |=> !irq_out);

  p_unmapped_r12: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && paddr >= 12'h010 && paddr < 12'hFD0) |-> (prdata == '0));

endmodule

bind apb_dcount_timer dtimer_chk #(.W(DATA_W)) i_chk (
  .pclk      (pclk),
  .presetn   (presetn),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .wbit0     (pwdata[0]),
  .prdata    (prdata),
  .irq_out   (irq_out),
  .tick      (tick),
  .cnt_val   (cnt_val),
  .rel_val   (rel_val),
  .ctrl_bits (ctrl_q)
);

// File: tb/test_apb_dcount_timer.sv
module test_apb_dcount_timer;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_CNT  = 12'h004;
  localparam logic [11:0] A_REL  = 12'h008;
  localparam logic [11:0] A_FLG  = 12'h00C;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic        ext_in = 1'b0;
  logic        irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  apb_dcount_timer i_apb_dcount_timer (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .ext_in  (ext_in),
    .irq_out (irq_out)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] expv;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 12'h000, 32'hFFFF_FFF6, 32'h0000_0006, "R2 "},
    '{1'b1, 12'h008, 32'h0000_1234, 32'h0000_1234, "R7 "},
    '{1'b0, 12'h004, 32'h0000_0000, 32'h0000_1234, "R7 "},
    '{1'b1, 12'h004, 32'h0000_0055, 32'h0000_0055, "R7 "},
    '{1'b0, 12'h008, 32'h0000_0000, 32'h0000_1234, "R7 "},
    '{1'b1, 12'hFE0, 32'h0000_00FF, 32'h0000_0022, "R11"},
    '{1'b0, 12'hFD0, 32'h0000_0000, 32'h0000_0004, "R11"},
    '{1'b0, 12'hFE4, 32'h0000_0000, 32'h0000_00B8, "R11"},
    '{1'b0, 12'hFE8, 32'h0000_0000, 32'h0000_001B, "R11"},
    '{1'b0, 12'hFF0, 32'h0000_0000, 32'h0000_000D, "R11"},
    '{1'b0, 12'hFFC, 32'h0000_0000, 32'h0000_00B1, "R11"},
    '{1'b1, 12'h010, 32'h0000_FFFF, 32'h0000_0000, "R12"},
    '{1'b0, 12'h000, 32'h0000_0000, 32'h0000_0006, "R12"},
    '{1'b0, 12'hF00, 32'h0000_0000, 32'h0000_0000, "R12"}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
    end
  endtask

  // Called at a falling edge; write lands on the second rising edge
  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  // Combinational read, no clock edge passes
  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    #1;
    d = prdata;
  endtask

  task automatic chk_cnt(input string tag, input logic [31:0] expv);
    logic [31:0] v;
    peek(A_CNT, v);
    chk(tag, v, expv);
  endtask

  task automatic chk_irq(input string tag, input logic expv);
    chk(tag, {31'b0, irq_out}, {31'b0, expv});
  endtask

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge pclk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rv;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R1 reset state
    peek(A_CTRL, rv); chk("R1 ctrl", rv, 32'h0);
    peek(A_CNT, rv);  chk("R1 count", rv, 32'h0);
    peek(A_REL, rv);  chk("R1 reload", rv, 32'h0);
    peek(A_FLG, rv);  chk("R1 flag", rv, 32'h0);
    chk_irq("R1 irq", 1'b0);
    chk("R1 pready", {31'b0, pready}, 32'h1);
    chk("R1 pslverr", {31'b0, pslverr}, 32'h0);

    // Register table, counter kept stopped
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) apb_write(VECS[i].addr, VECS[i].wdata);
      peek(VECS[i].addr, rv);
      chk(string'(VECS[i].tag), rv, VECS[i].expv);
    end
    apb_write(A_CTRL, 32'h0);

    // R3/R4/R5 periodic countdown with interrupt
    apb_write(A_REL, 32'd3);
    apb_write(A_CTRL, 32'h9);
    chk_cnt("R3 start", 32'd3);
    @(negedge pclk); chk_cnt("R3 step", 32'd2);
    @(negedge pclk); chk_cnt("R3 step", 32'd1);
    @(negedge pclk); chk_cnt("R4 zero", 32'd0); chk_irq("R4 set", 1'b1);
    @(negedge pclk); chk_cnt("R5 reload", 32'd3);
    apb_write(A_FLG, 32'h1);
    chk_cnt("R8 count", 32'd1); chk_irq("R8 clear", 1'b0);
    @(negedge pclk); chk_irq("R4 again", 1'b1);
    apb_write(A_CTRL, 32'h0);
    chk_cnt("R3 stop", 32'd2);
    repeat (3) @(negedge pclk);
    chk_cnt("R3 held", 32'd2);
    apb_write(A_FLG, 32'h1);
    chk_irq("R8 clear", 1'b0);

    // R4 interrupt enable clear
    apb_write(A_REL, 32'd2);
    apb_write(A_CTRL, 32'h1);
    @(negedge pclk); chk_cnt("R3 noirq", 32'd1);
    @(negedge pclk); chk_cnt("R4 noirq zero", 32'd0); chk_irq("R4 masked", 1'b0);
    @(negedge pclk); chk_cnt("R5 reload", 32'd2); chk_irq("R4 masked", 1'b0);
    apb_write(A_CTRL, 32'h0);

    // R6 zero reload
    apb_write(A_REL, 32'd0);
    apb_write(A_CTRL, 32'h9);
    repeat (6) @(negedge pclk);
    chk_cnt("R6 idle", 32'd0); chk_irq("R6 idle", 1'b0);
    apb_write(A_CNT, 32'd2);
    chk_cnt("R7 count write", 32'd2);
    @(negedge pclk); chk_cnt("R6 step", 32'd1);
    @(negedge pclk); chk_irq("R6 oneshot", 1'b1);
    repeat (3) @(negedge pclk);
    chk_cnt("R6 stays", 32'd0);
    apb_write(A_CTRL, 32'h0);
    apb_write(A_FLG, 32'h1);

    // R8 clear colliding with a 1-to-0 step
    apb_write(A_REL, 32'd3);
    apb_write(A_CTRL, 32'h9);
    @(negedge pclk);
    apb_write(A_FLG, 32'h1);
    chk_cnt("R8 collide", 32'd0); chk_irq("R8 set wins", 1'b1);
    apb_write(A_CTRL, 32'h0);
    apb_write(A_FLG, 32'h1);

    // R9 external gate
    apb_write(A_REL, 32'd5);
    apb_write(A_CTRL, 32'hB);
    repeat (4) @(negedge pclk);
    chk_cnt("R9 gated low", 32'd5);
    ext_in = 1'b1;
    @(negedge pclk); chk_cnt("R9 sync1", 32'd5);
    @(negedge pclk); chk_cnt("R9 sync2", 32'd5);
    @(negedge pclk); chk_cnt("R9 run", 32'd4);
    @(negedge pclk); chk_cnt("R9 run", 32'd3);
    ext_in = 1'b0;
    @(negedge pclk); chk_cnt("R9 tail", 32'd2);
    @(negedge pclk); chk_cnt("R9 tail", 32'd1);
    repeat (2) @(negedge pclk);
    chk_cnt("R9 stopped", 32'd1);
    apb_write(A_CTRL, 32'h0);

    // R10 external tick on rising edges
    apb_write(A_REL, 32'd10);
    apb_write(A_CTRL, 32'h5);
    for (int p = 0; p < 4; p++) begin
      ext_in = 1'b1;
      repeat (3) @(negedge pclk);
      ext_in = 1'b0;
      repeat (3) @(negedge pclk);
      if (p == 0) chk_cnt("R10 one pulse", 32'd9);
    end
    repeat (4) @(negedge pclk);
    chk_cnt("R10 four pulses", 32'd6);

    // R1 reset while running
    apb_write(A_CTRL, 32'h9);
    presetn = 1'b0;
    #1;
    peek(A_CTRL, rv); chk("R1 ctrl", rv, 32'h0);
    peek(A_CNT, rv);  chk("R1 count", rv, 32'h0);
    peek(A_REL, rv);  chk("R1 reload", rv, 32'h0);
    chk_irq("R1 irq", 1'b0);
    @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule